// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Cluster

This block is a cluster of sixteen programmable logic elements. Each element pairs a 4-input lookup table with one flip-flop. A per-element mode field chooses how the two are wired. In combinational mode the table drives the element output. In registered mode the flip-flop drives it. In packed mode the table and the flip-flop serve two unrelated functions, and the flip-flop captures a direct data input. In shift mode the flip-flop captures its lower neighbour's flip-flop, so the cluster forms a 16-stage shift register while the tables keep computing logic. In arithmetic mode each element is one full-adder bit, and a dedicated ripple carry runs from element 0 up to element 15.

The clock, the asynchronous active-low reset and the clock enable are shared by all sixteen elements. The configuration (one 16-bit table mask and one 3-bit mode code per element, 304 bits in total) arrives through a one-bit serial port. A small loader state machine has three states. LD_EMPTY means nothing has been loaded since reset. LD_SHIFT means a load is under way. LD_READY means a complete image is held.

The loader takes these transitions:
- A bit with `cfg_en` high in LD_EMPTY or LD_READY moves to LD_SHIFT.
- A bit with `cfg_en` high in LD_SHIFT stays there until the 304th bit, which moves to LD_READY.
- `cfg_en` low holds the current state, so a load may pause.
- Reset returns to LD_EMPTY from any state.

All logic outputs are held at zero and the flip-flops are frozen whenever the loader is not in LD_READY.

Top module: `lut_cluster`

## Requirements
- R1: Configuration bits are shifted in on `cfg_din` at rising clock edges where `cfg_en` is 1, first bit first. Once 304 bits have arrived, bit k of the loaded image is the k-th bit sent, counting from 0. Element i owns image bits [19i+18:19i]: its table mask is bits [19i+15:19i] and its mode code is bits [19i+18:19i+16]. `cfg_done` becomes 1 at the edge that takes the 304th bit, and low `cfg_en` cycles inside a load only pause it.
- R2: While `cfg_done` is 0 (after reset, or during a load or reload), `y_o`, `q_o`, `shift_out` and `carry_out` read 0 and no element flip-flop changes. The flip-flops keep their values across a reload.
- R3: The table value of element i is mask bit number `lut_in[4i+3:4i]`, with input 0 as the least significant index bit. Mode code 0 (combinational) drives `y_o[i]` with that value. Codes 5, 6 and 7 behave exactly like code 0.
- R4: Mode code 1 (registered) drives `y_o[i]` from the flip-flop, and the flip-flop captures the table value at each enabled edge. Codes 0, 5, 6 and 7 also capture the table value.
- R5: Mode code 2 (packed) drives `y_o[i]` with the table value, and the flip-flop captures `dir_in[i]` at each enabled edge.
- R6: Mode code 3 (shift) drives `y_o[i]` with the table value. The flip-flop captures element i-1's flip-flop at each enabled edge, and element 0 captures `shift_in`. `shift_out` shows element 15's flip-flop.
- R7: Mode code 4 (arithmetic) adds `lut_in[4i]`, the table value and the incoming carry. `y_o[i]` is the sum, the flip-flop captures the sum, and the carry goes to element i+1. `carry_in` feeds element 0, and `carry_out` is element 15's carry. An element in any other mode passes on a carry of 0.
- R8: `q_o[i]` always shows element i's flip-flop (subject to R2), in every mode.
- R9: With `ce` at 0, no flip-flop changes at an edge, while the table, sum and carry outputs still follow their inputs.
- R10: `rst_n` at 0 clears every flip-flop and returns the loader to the unloaded state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cluster clock |
| rst_n | input | 1 | Shared asynchronous reset, active low |
| ce | input | 1 | Shared flip-flop clock enable |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, first bit first |
| cfg_done | output | 1 | Complete configuration held |
| lut_in | input | 64 | Table inputs, element i uses bits [4i+3:4i] |
| dir_in | input | 16 | Direct flip-flop data for packed mode |
| shift_in | input | 1 | Shift chain input to element 0 |
| carry_in | input | 1 | Carry into element 0 |
| y_o | output | 16 | Per-element primary output |
| q_o | output | 16 | Per-element flip-flop output |
| shift_out | output | 1 | Element 15 flip-flop, end of shift chain |
| carry_out | output | 1 | Carry out of element 15 |

## Verification
The bench checks table indexing on mixed parity and AND masks, with odd elements using an undefined mode code. A reversed index or a decoder that drops the alias would show wrong output bits. It walks an adder vector table that includes full carry ripple from bit 0 to the top and a borrow-style subtract through an inverted-operand mask. A broken carry chain would show as a wrong high sum or a wrong `carry_out`, and a non-arithmetic element that leaked a carry would show as a wrong `carry_out` on a half-arithmetic cluster. Partial loads and reloads must keep every output at zero while keeping the flip-flop contents, which the shift test then reads back. An asynchronous reset between edges must clear the registers and the loaded state at once.

// File: rtl/lut_le_pkg.sv
package lut_le_pkg;
    localparam int LUT_K  = 4;
    localparam int MASK_W = 1 << LUT_K;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        LE_COMB  = 3'd0,
        LE_REG   = 3'd1,
        LE_PACK  = 3'd2,
        LE_SHIFT = 3'd3,
        LE_ARITH = 3'd4
    } le_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [MASK_W-1:0] mask;
    } le_cfg_t;

    localparam int CFG_W = $bits(le_cfg_t);

    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_SHIFT = 2'd1,
        LD_READY = 2'd2
    } ld_state_e;
endpackage

// File: rtl/le_cfg_loader.sv
module le_cfg_loader
    import lut_le_pkg::*;
#(
    parameter int N_ELEM = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en,
    input  logic                      cfg_din,
    output logic                      cfg_ready,
    output logic [N_ELEM*CFG_W-1:0]   cfg_word
);
    localparam int TOTAL = N_ELEM * CFG_W;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

    ld_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TOTAL-1:0] sreg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LD_EMPTY, LD_READY: begin
                if (cfg_en) begin
                    state_d = LD_SHIFT;
                    cnt_d   = CNT_W'(1);
                end
            end
            LD_SHIFT: begin
                if (cfg_en) begin
                    if (cnt_q == LAST) begin
                        state_d = LD_READY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = LD_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // configuration shift register, first bit ends at position 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (cfg_en) begin
            sreg_q <= {cfg_din, sreg_q[TOTAL-1:1]};
        end
    end

    // outputs
    always_comb begin
        cfg_ready = (state_q == LD_READY);
        cfg_word  = sreg_q;
    end

    // R1
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_SHIFT && cfg_en && cnt_q == LAST) |=> cfg_ready);

    // R2
    mid_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !(state_q == LD_SHIFT && cnt_q == LAST)) |=> !cfg_ready);
endmodule

// File: rtl/lut_le.sv
module lut_le
    import lut_le_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  le_cfg_t          cfg,
    input  logic [LUT_K-1:0] lut_d,
    input  logic             dir_d,
    input  logic             chain_d,
    input  logic             cin,
    output logic             y,
    output logic             q,
    output logic             cout
);
    le_mode_e mode_e;
    logic     lut_val, sum, carry, nxt, q_q;

    // mode decode, undefined codes alias to combinational
    always_comb begin
        unique case (cfg.mode)
            3'd1:    mode_e = LE_REG;
            3'd2:    mode_e = LE_PACK;
            3'd3:    mode_e = LE_SHIFT;
            3'd4:    mode_e = LE_ARITH;
            default: mode_e = LE_COMB;
        endcase
    end

    always_comb begin
        lut_val = cfg.mask[lut_d];
        sum     = lut_d[0] ^ lut_val ^ cin;
        carry   = (lut_d[0] & lut_val) | (cin & (lut_d[0] ^ lut_val));
    end

    // output and next-register selection per mode
    always_comb begin
        y    = lut_val;
        nxt  = lut_val;
        cout = 1'b0;
        unique case (mode_e)
            LE_COMB:  begin y = lut_val; nxt = lut_val; end
            LE_REG:   begin y = q_q;     nxt = lut_val; end
            LE_PACK:  begin y = lut_val; nxt = dir_d;   end
            LE_SHIFT: begin y = lut_val; nxt = chain_d; end
            LE_ARITH: begin y = sum;     nxt = sum; cout = carry; end
            default:  begin y = lut_val; nxt = lut_val; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else if (upd) begin
            q_q <= nxt;
        end
    end

    assign q = q_q;

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q_q));

    // R5
    packed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode_e == LE_PACK) |=> (q_q == $past(dir_d)));
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
    import lut_le_pkg::*;
#(
    parameter int N_ELEM = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic                    cfg_en,
    input  logic                    cfg_din,
    output logic                    cfg_done,
    input  logic [N_ELEM*LUT_K-1:0] lut_in,
    input  logic [N_ELEM-1:0]       dir_in,
    input  logic                    shift_in,
    input  logic                    carry_in,
    output logic [N_ELEM-1:0]       y_o,
    output logic [N_ELEM-1:0]       q_o,
    output logic                    shift_out,
    output logic                    carry_out
);
    localparam int TOTAL = N_ELEM * CFG_W;

    logic [TOTAL-1:0]  cfg_word;
    logic              ready;
    logic              upd;
    logic [N_ELEM:0]   carry;
    logic [N_ELEM-1:0] y_int, q_int;
    le_cfg_t           cfg_vec [N_ELEM];

    le_cfg_loader #(.N_ELEM(N_ELEM)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_din   (cfg_din),
        .cfg_ready (ready),
        .cfg_word  (cfg_word)
    );

    assign upd      = ready & ce;
    assign carry[0] = carry_in;

    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        logic chain_src;
        assign cfg_vec[g] = le_cfg_t'(cfg_word[g*CFG_W +: CFG_W]);
        if (g == 0) begin : g_head
            assign chain_src = shift_in;
        end else begin : g_link
            assign chain_src = q_int[g-1];

            // R6
            shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (upd && cfg_vec[g].mode == 3'd3) |=> (q_int[g] == $past(q_int[g-1])));
        end

        lut_le u_le (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (upd),
            .cfg     (cfg_vec[g]),
            .lut_d   (lut_in[g*LUT_K +: LUT_K]),
            .dir_d   (dir_in[g]),
            .chain_d (chain_src),
            .cin     (carry[g]),
            .y       (y_int[g]),
            .q       (q_int[g]),
            .cout    (carry[g+1])
        );
    end

    always_comb begin
        cfg_done  = ready;
        y_o       = ready ? y_int : '0;
        q_o       = ready ? q_int : '0;
        shift_out = ready & q_int[N_ELEM-1];
        carry_out = ready & carry[N_ELEM];
    end
endmodule

// File: tb/lut_cluster_tb.sv
`timescale 1ns/1ps
module lut_cluster_tb;
    localparam int N = 16;
    localparam int CW = 19;
    localparam int TOT = N * CW;

    // {a, b, cin, sum, cout}
    localparam logic [49:0] ADD_TAB [6] = '{
        {16'h0001, 16'hFFFF, 1'b0, 16'h0000, 1'b1},
        {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
        {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
        {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
        {16'h00FF, 16'h0F0F, 1'b1, 16'h100F, 1'b0},
        {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0}
    };

    logic clk = 0, rst_n = 0, ce = 0, cfg_en = 0, cfg_din = 0;
    logic [63:0] lut_in = '0;
    logic [15:0] dir_in = '0;
    logic shift_in = 0, carry_in = 0;
    logic cfg_done, shift_out, carry_out;
    logic [15:0] y_o, q_o;

    logic [CW-1:0] cw [N];
    logic [TOT-1:0] flat;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    lut_cluster u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .lut_in(lut_in), .dir_in(dir_in), .shift_in(shift_in),
        .carry_in(carry_in), .y_o(y_o), .q_o(q_o), .shift_out(shift_out),
        .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_all(input logic [2:0] mode, input logic [15:0] mask);
        for (int i = 0; i < N; i++) cw[i] = {mode, mask};
    endtask

    task automatic pack_cfg();
        for (int i = 0; i < N; i++) flat[i*CW +: CW] = cw[i];
    endtask

    task automatic send_bits(input int lo, input int hi);
        for (int b = lo; b <= hi; b++) begin
            @(negedge clk);
            cfg_en = 1; cfg_din = flat[b];
        end
        @(negedge clk);
        cfg_en = 0;
    endtask

    function automatic logic [15:0] comb_exp(input logic [63:0] li);
        logic [15:0] r;
        for (int i = 0; i < N; i++) begin
            if (i % 2 == 0) r[i] = ^li[i*4 +: 4];
            else            r[i] = (li[i*4 +: 4] == 4'hF);
        end
        return r;
    endfunction

    function automatic logic [63:0] ab_in(input logic [15:0] a, input logic [15:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) begin
            r[i*4]   = a[i];
            r[i*4+1] = b[i];
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] pats [3];
        logic [15:0] mq;
        pats[0] = 64'h0123456789ABCDEF;
        pats[1] = 64'hFFFF0000F0F01248;
        pats[2] = 64'hF0F0FFFF00001111;

        // reset state (R10, R2)
        repeat (2) @(negedge clk);
        chk("R10 reset cfg_done", cfg_done, 0);
        chk("R2 reset y_o", y_o, 0);
        chk("R2 reset q_o", q_o, 0);
        rst_n = 1;

        // mixed combinational config: even parity code 0, odd AND4 code 7
        for (int i = 0; i < N; i++)
            cw[i] = (i % 2 == 0) ? {3'd0, 16'h6996} : {3'd7, 16'h8000};
        pack_cfg();
        lut_in = pats[0];
        send_bits(0, 99);
        repeat (3) @(negedge clk);
        chk("R2 partial load cfg_done", cfg_done, 0);
        chk("R2 partial load y_o", y_o, 0);
        send_bits(100, TOT - 1);
        chk("R1 cfg_done after full load", cfg_done, 1);
        ce = 0;
        for (int p = 0; p < 3; p++) begin
            lut_in = pats[p];
            #1;
            chk("R3 comb/alias lookup", y_o, comb_exp(pats[p]));
            @(negedge clk);
            chk("R9 ce low comb output live", y_o, comb_exp(pats[p]));
        end
        chk("R9 ce low regs hold", q_o, 0);

        // registered mode, mask true only at index 1
        set_all(3'd1, 16'h0002); pack_cfg();
        send_bits(0, TOT - 1);
        lut_in = 64'h0101010101010101;
        #1;
        chk("R4 reg output before edge", y_o, 0);
        ce = 1;
        @(negedge clk);
        chk("R4 reg output after edge", y_o, 16'h5555);
        chk("R8 q_o follows register", q_o, 16'h5555);
        ce = 0; lut_in = 64'h1111111111111111;
        @(negedge clk);
        chk("R9 ce low register hold", y_o, 16'h5555);
        ce = 1;
        @(negedge clk);
        chk("R4 reg reload", q_o, 16'hFFFF);

        // packed mode
        set_all(3'd2, 16'h6996); pack_cfg();
        ce = 0;
        send_bits(0, TOT - 1);
        lut_in = pats[0]; dir_in = 16'hA5C3; ce = 1;
        @(negedge clk);
        chk("R5 packed register takes dir_in", q_o, 16'hA5C3);
        mq = '0;
        for (int i = 0; i < N; i++) mq[i] = ^pats[0][i*4 +: 4];
        chk("R5 packed table independent", y_o, mq);

        // shift mode, reload keeps register contents
        set_all(3'd3, 16'hFFFF); pack_cfg();
        send_bits(0, 149);
        chk("R2 reload gates q_o", q_o, 0);
        send_bits(150, TOT - 1);
        chk("R2 registers kept across reload", q_o, 16'hA5C3);
        chk("R6 shift mode table output", y_o, 16'hFFFF);
        mq = 16'hA5C3;
        for (int s = 0; s < 4; s++) begin
            shift_in = (s % 3 == 0);
            mq = {mq[14:0], shift_in};
            @(negedge clk);
            chk("R6 shift step", q_o, mq);
            chk("R6 shift_out", shift_out, mq[15]);
        end

        // arithmetic: table passes b (mask CCCC)
        set_all(3'd4, 16'hCCCC); pack_cfg();
        send_bits(0, TOT - 1);
        foreach (ADD_TAB[k]) begin
            lut_in = ab_in(ADD_TAB[k][49:34], ADD_TAB[k][33:18]);
            carry_in = ADD_TAB[k][17];
            #1;
            chk("R7 adder sum", y_o, ADD_TAB[k][16:1]);
            chk("R7 adder carry_out", carry_out, ADD_TAB[k][0]);
            @(negedge clk);
            chk("R7 register captures sum", q_o, ADD_TAB[k][16:1]);
        end

        // subtract: table inverts b (mask 3333), carry_in 1
        set_all(3'd4, 16'h3333); pack_cfg();
        send_bits(0, TOT - 1);
        lut_in = ab_in(16'h0005, 16'h0003); carry_in = 1; #1;
        chk("R7 subtract 5-3", y_o, 16'h0002);
        chk("R7 subtract no borrow", carry_out, 1);
        lut_in = ab_in(16'h0003, 16'h0005); #1;
        chk("R7 subtract 3-5", y_o, 16'hFFFE);
        chk("R7 subtract borrow", carry_out, 0);

        // half arithmetic, upper half combinational with zero mask
        for (int i = 0; i < N; i++)
            cw[i] = (i < 8) ? {3'd4, 16'hCCCC} : {3'd0, 16'h0000};
        pack_cfg();
        send_bits(0, TOT - 1);
        lut_in = ab_in(16'h00FF, 16'h0001); carry_in = 0; #1;
        chk("R7 non-arith element blocks carry", carry_out, 0);
        chk("R7 half adder sum", y_o, 16'h0000);

        // asynchronous reset between edges
        @(negedge clk);
        #2 rst_n = 0;
        #1;
        chk("R10 async reset cfg_done", cfg_done, 0);
        chk("R10 async reset q_o", q_o, 0);
        @(negedge clk);
        rst_n = 1; ce = 0;
        set_all(3'd1, 16'hFFFF); pack_cfg();
        send_bits(0, TOT - 1);
        chk("R10 registers cleared by reset", y_o, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule